// File: doc/BRIEF.md
# Converter Self-Calibration Start Sequencer

This block decides when a data converter runs its self-calibration and tells the rest of the chip while a calibration is in progress. A calibration starts in one of two ways. The first is automatic: a wait that begins when the block leaves reset. The second is a request on a synchronous input that shows a long low stretch followed by a long high stretch. The trimming work itself is outside the block. Here it is a busy window of fixed length, and a parameter sets that length in cycles.

Two inputs choose the wait after reset. One selects the short or the long delay. The other marks that the converter is under serial register control. In that mode the delay-select pin is in use for another purpose, so the block always takes the short delay. While calibration runs, the block raises a running flag and holds the enable of the sampled-data output clock low. That clock stays quiet from the first busy cycle until one cycle after the busy window ends.

Top module: `cal_sequencer`

## Requirements
- R1: A request is accepted only after at least LOW_RUN consecutive samples of calReq at 0 followed by at least HIGH_RUN consecutive samples at 1. calRunning goes high on the clock edge after the edge that samples the HIGH_RUN-th 1.
- R2: Once raised, calRunning stays high for exactly CAL_CYCLES clock cycles and then goes low.
- R3: After reset is released, calRunning rises on the (D+1)-th rising edge, where D is SHORT_DELAY when longDelay=0 and LONG_DELAY when longDelay=1. The select is taken on the first edge after release.
- R4: With extCtrlMode=1, the short delay SHORT_DELAY is used whatever the value of longDelay.
- R5: outClkEnable is 0 in every cycle in which calRunning is 1.
- R6: outClkEnable stays 0 for one further cycle after calRunning falls. In every other cycle it is 1, including before the first calibration.
- R7: A qualifying request pattern that completes while calibration runs is dropped and never starts a later calibration.
- R8: A low stretch shorter than LOW_RUN, or a high stretch cut short by a 0, discards the progress made so far. The next attempt needs a new full low stretch.
- R9: Asserting rstN low (asynchronous, active low) at once forces calRunning=0 and outClkEnable=1. Releasing it restarts the power-up delay.
- R10: A qualifying request that completes during the power-up wait starts calibration at once, as in R1, and cancels the pending automatic start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter input clock |
| rstN | input | 1 | Asynchronous active-low reset; its release is the power-up event |
| calReq | input | 1 | Synchronous calibration request line |
| extCtrlMode | input | 1 | 1 = serial register control active; forces the short power-up delay |
| longDelay | input | 1 | 1 = long power-up delay, 0 = short |
| calRunning | output | 1 | High while a calibration is in progress |
| outClkEnable | output | 1 | Enable for the sampled-data output clock; 0 = held still |

## Verification
On every cycle the assertions check how the running flag and the clock enable relate: the gate is closed while the flag is high, it stays closed for exactly one trailing cycle, and it is open otherwise. They also check that each busy window is exactly CAL_CYCLES long, using a counter. Only the bench scenarios can show when a calibration starts. That covers the exact start cycle after a low/high request, the rejection of stretches one sample too short, the short and long power-up delays under each mode setting, requests that are dropped during a run, and the restart after a reset in mid-calibration.

// File: rtl/cal_seq_pkg.sv
`timescale 1ns/1ps
package cal_seq_pkg;

  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_PWR  = 2'd1,
    ST_IDLE = 2'd2,
    ST_RUN  = 2'd3
  } calState_e;

  typedef struct packed {
    logic loadDelay;
    logic decDelay;
    logic loadBusy;
    logic decBusy;
  } calStrobes_t;

endpackage

// File: rtl/cal_seq_datapath.sv
`timescale 1ns/1ps
module cal_seq_datapath
  import cal_seq_pkg::*;
#(
  parameter int LOW_RUN     = 80,
  parameter int HIGH_RUN    = 80,
  parameter int SHORT_DELAY = 256,
  parameter int LONG_DELAY  = 16384,
  parameter int CAL_CYCLES  = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        calReq,
  input  logic        extCtrlMode,
  input  logic        longDelay,
  input  calStrobes_t strobes,
  input  logic        calRunning,
  output logic        patternHit,
  output logic        delayDone,
  output logic        busyDone,
  output logic        outClkEnable
);

  localparam int MAX_DELAY = (LONG_DELAY > SHORT_DELAY) ? LONG_DELAY : SHORT_DELAY;
  localparam int LOW_W  = $clog2(LOW_RUN + 1);
  localparam int HIGH_W = $clog2(HIGH_RUN + 1);
  localparam int DLY_W  = $clog2(MAX_DELAY + 1);
  localparam int BUSY_W = $clog2(CAL_CYCLES + 1);

  localparam logic [LOW_W-1:0]  LOW_FULL   = LOW_W'(LOW_RUN);
  localparam logic [LOW_W-1:0]  LOW_ONE    = LOW_W'(1);
  localparam logic [HIGH_W-1:0] HIGH_LAST  = HIGH_W'(HIGH_RUN - 1);
  localparam logic [HIGH_W-1:0] HIGH_ONE   = HIGH_W'(1);
  localparam logic [DLY_W-1:0]  SHORT_LAST = DLY_W'(SHORT_DELAY - 1);
  localparam logic [DLY_W-1:0]  LONG_LAST  = DLY_W'(LONG_DELAY - 1);
  localparam logic [DLY_W-1:0]  DLY_ONE    = DLY_W'(1);
  localparam logic [BUSY_W-1:0] BUSY_LAST  = BUSY_W'(CAL_CYCLES - 1);
  localparam logic [BUSY_W-1:0] BUSY_ONE   = BUSY_W'(1);

  logic [LOW_W-1:0]  lowCnt;
  logic [HIGH_W-1:0] highCnt;
  logic              hitQ;
  logic [DLY_W-1:0]  dlyCnt;
  logic [BUSY_W-1:0] busyCnt;
  logic              tailQ;
  logic              useLong;

  // Request pattern detector: saturating low-run count, then high-run count.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      highCnt <= '0;
      hitQ    <= 1'b0;
    end else begin
      hitQ <= 1'b0;
      if (!calReq) begin
        highCnt <= '0;
        if (highCnt != '0)          lowCnt <= LOW_ONE;
        else if (lowCnt != LOW_FULL) lowCnt <= lowCnt + LOW_ONE;
      end else if (lowCnt != LOW_FULL) begin
        lowCnt  <= '0;
        highCnt <= '0;
      end else if (highCnt == HIGH_LAST) begin
        hitQ    <= 1'b1;
        lowCnt  <= '0;
        highCnt <= '0;
      end else begin
        highCnt <= highCnt + HIGH_ONE;
      end
    end
  end

  // Serial control reuses the select pin, so the long delay is masked off.
  assign useLong = longDelay & ~extCtrlMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 dlyCnt <= '0;
    else if (strobes.loadDelay) dlyCnt <= useLong ? LONG_LAST : SHORT_LAST;
    else if (strobes.decDelay)  dlyCnt <= dlyCnt - DLY_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 busyCnt <= '0;
    else if (strobes.loadBusy) busyCnt <= BUSY_LAST;
    else if (strobes.decBusy)  busyCnt <= busyCnt - BUSY_ONE;
  end

  // One trailing cycle of gating after the busy window closes.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tailQ <= 1'b0;
    else       tailQ <= calRunning;
  end

  assign patternHit   = hitQ;
  assign delayDone    = (dlyCnt == '0);
  assign busyDone     = (busyCnt == '0);
  assign outClkEnable = ~(calRunning | tailQ);

endmodule

// File: rtl/cal_seq_ctrl.sv
`timescale 1ns/1ps
module cal_seq_ctrl
  import cal_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        patternHit,
  input  logic        delayDone,
  input  logic        busyDone,
  output calStrobes_t strobes,
  output logic        calRunning
);

  calState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_LOAD;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_LOAD: begin
        strobes.loadDelay = 1'b1;
        stateNext         = ST_PWR;
      end
      ST_PWR: begin
        if (patternHit || delayDone) begin
          strobes.loadBusy = 1'b1;
          stateNext        = ST_RUN;
        end else begin
          strobes.decDelay = 1'b1;
        end
      end
      ST_IDLE: begin
        if (patternHit) begin
          strobes.loadBusy = 1'b1;
          stateNext        = ST_RUN;
        end
      end
      ST_RUN: begin
        // A request completing here is dropped on purpose.
        if (busyDone) stateNext = ST_IDLE;
        else          strobes.decBusy = 1'b1;
      end
      default: stateNext = ST_LOAD;
    endcase
  end

  assign calRunning = (state == ST_RUN);

endmodule

// File: rtl/cal_sequencer.sv
`timescale 1ns/1ps
module cal_sequencer
  import cal_seq_pkg::*;
#(
  parameter int LOW_RUN     = 80,
  parameter int HIGH_RUN    = 80,
  parameter int SHORT_DELAY = 256,
  parameter int LONG_DELAY  = 16384,
  parameter int CAL_CYCLES  = 1024
) (
  input  logic clk,
  input  logic rstN,
  input  logic calReq,
  input  logic extCtrlMode,
  input  logic longDelay,
  output logic calRunning,
  output logic outClkEnable
);

  calStrobes_t strobes;
  logic        patternHit;
  logic        delayDone;
  logic        busyDone;

  cal_seq_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .patternHit (patternHit),
    .delayDone  (delayDone),
    .busyDone   (busyDone),
    .strobes    (strobes),
    .calRunning (calRunning)
  );

  cal_seq_datapath #(
    .LOW_RUN     (LOW_RUN),
    .HIGH_RUN    (HIGH_RUN),
    .SHORT_DELAY (SHORT_DELAY),
    .LONG_DELAY  (LONG_DELAY),
    .CAL_CYCLES  (CAL_CYCLES)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .calReq       (calReq),
    .extCtrlMode  (extCtrlMode),
    .longDelay    (longDelay),
    .strobes      (strobes),
    .calRunning   (calRunning),
    .patternHit   (patternHit),
    .delayDone    (delayDone),
    .busyDone     (busyDone),
    .outClkEnable (outClkEnable)
  );

endmodule

// File: rtl/cal_sequencer_checker.sv
`timescale 1ns/1ps
module cal_sequencer_checker #(
  parameter int CAL_CYCLES = 1024
) (
  input logic clk,
  input logic rstN,
  input logic calRunning,
  input logic outClkEnable
);

  localparam int RUN_W = $clog2(CAL_CYCLES + 2);

  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          runLen <= '0;
    else if (calRunning) runLen <= runLen + RUN_W'(1);
    else                 runLen <= '0;
  end

  assert_gate_closed_R5: assert property (@(posedge clk) disable iff (!rstN)
    calRunning |-> !outClkEnable);

  assert_gate_tail_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(calRunning) |-> !outClkEnable);

  assert_gate_open_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!calRunning && !$past(calRunning)) |-> outClkEnable);

  assert_run_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    calRunning |-> (runLen < RUN_W'(CAL_CYCLES)));

  assert_run_length_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(calRunning) |-> (runLen == RUN_W'(CAL_CYCLES)));

endmodule

bind cal_sequencer cal_sequencer_checker #(.CAL_CYCLES(CAL_CYCLES)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .calRunning   (calRunning),
  .outClkEnable (outClkEnable)
);

// File: tb/cal_sequencer_tb_top.sv
`timescale 1ns/1ps
module cal_sequencer_tb_top;

  localparam int LOW   = 6;
  localparam int HIGH  = 6;
  localparam int SHORT = 8;
  localparam int LONG  = 20;
  localparam int CAL   = 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic calReq = 1'b1;
  logic extCtrlMode = 1'b0;
  logic longDelay = 1'b0;
  logic calRunning;
  logic outClkEnable;

  int cycle = 0;
  int nChecks = 0;
  int nErr = 0;
  int riseCount = 0;
  int riseAt = 0;
  int fallAt = 0;
  int gateBad = 0;
  int rel = 0;
  logic prevRun = 1'b0;

  always #4 clk = ~clk;

  cal_sequencer #(
    .LOW_RUN(LOW), .HIGH_RUN(HIGH), .SHORT_DELAY(SHORT),
    .LONG_DELAY(LONG), .CAL_CYCLES(CAL)
  ) dut_i (
    .clk(clk), .rstN(rstN), .calReq(calReq), .extCtrlMode(extCtrlMode),
    .longDelay(longDelay), .calRunning(calRunning), .outClkEnable(outClkEnable)
  );

  always @(posedge clk) cycle <= cycle + 1;

  always @(negedge clk) begin
    if (!rstN) prevRun = 1'b0;
    else begin
      if (outClkEnable !== !(calRunning || prevRun)) gateBad++;
      if (calRunning && !prevRun) begin riseCount++; riseAt = cycle; end
      if (!calRunning && prevRun) fallAt = cycle;
      prevRun = calRunning;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  task automatic hold(input logic v, input int n);
    calReq = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic enterReset();
    @(negedge clk);
    #1 rstN = 1'b0;
    #1;
  endtask

  task automatic leaveReset();
    @(negedge clk);
    rstN = 1'b1;
    riseCount = 0;
    gateBad = 0;
    rel = cycle;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    // R9: reset state
    #2;
    check(calRunning === 1'b0, "R9 reset running", int'(calRunning), 0);
    check(outClkEnable === 1'b1, "R9 reset clk enable", int'(outClkEnable), 1);

    // R3 / R4: power-up delay under every select/mode combination
    for (int m = 0; m < 4; m++) begin
      int d;
      extCtrlMode = m[1];
      longDelay   = m[0];
      calReq      = 1'b1;
      d = (m == 1) ? LONG : SHORT;
      enterReset();
      leaveReset();
      repeat (d + CAL + 6) @(negedge clk);
      check(riseCount == 1, m[1] ? "R4 powerup count" : "R3 powerup count", riseCount, 1);
      check(riseAt == rel + d + 1, m[1] ? "R4 powerup start" : "R3 powerup start",
            riseAt - rel, d + 1);
      check(fallAt - riseAt == CAL, "R2 busy length", fallAt - riseAt, CAL);
      check(gateBad == 0, "R5 R6 clock gate", gateBad, 0);
    end

    // R1 / R8: sweep of low and high stretch lengths around the thresholds
    for (int l = LOW - 2; l <= LOW + 2; l++) begin
      for (int h = HIGH - 2; h <= HIGH + 2; h++) begin
        int hStart;
        bit expect1;
        expect1 = (l >= LOW) && (h >= HIGH);
        hold(1'b1, 3);
        riseCount = 0; gateBad = 0;
        hold(1'b0, l);
        hStart = cycle;
        hold(1'b1, h);
        hold(1'b0, 2);
        hold(1'b1, CAL + 12);
        check(riseCount == int'(expect1), "R1 pattern accept", riseCount, int'(expect1));
        if (expect1) begin
          check(riseAt == hStart + HIGH + 1, "R1 start cycle", riseAt - hStart, HIGH + 1);
          check(fallAt - riseAt == CAL, "R2 busy length", fallAt - riseAt, CAL);
        end
        check(gateBad == 0, "R6 clock gate", gateBad, 0);
      end
    end

    // R8: interrupted stretches need a fresh full low run
    riseCount = 0;
    hold(1'b0, LOW - 1); hold(1'b1, 1); hold(1'b0, LOW - 1); hold(1'b1, HIGH + 4);
    hold(1'b0, LOW); hold(1'b1, HIGH - 3); hold(1'b0, 3); hold(1'b1, HIGH + 4);
    hold(1'b0, 2); hold(1'b1, 10);
    check(riseCount == 0, "R8 interrupted stretch", riseCount, 0);

    // R7: request completed during a run is dropped
    riseCount = 0; gateBad = 0;
    hold(1'b0, LOW); hold(1'b1, HIGH);
    hold(1'b0, LOW); hold(1'b1, HIGH + 2);
    hold(1'b1, 2 * CAL);
    check(riseCount == 1, "R7 request in run ignored", riseCount, 1);
    check(gateBad == 0, "R5 clock gate", gateBad, 0);

    // R9: reset in mid-calibration, then delay restarts
    hold(1'b0, LOW); hold(1'b1, HIGH + 10);
    check(calRunning === 1'b1, "R9 run before reset", int'(calRunning), 1);
    extCtrlMode = 1'b0; longDelay = 1'b0;
    enterReset();
    check(calRunning === 1'b0, "R9 async clear running", int'(calRunning), 0);
    check(outClkEnable === 1'b1, "R9 async clear enable", int'(outClkEnable), 1);
    leaveReset();
    repeat (SHORT + 4) @(negedge clk);
    check(riseCount == 1 && riseAt == rel + SHORT + 1, "R9 delay restart",
          riseAt - rel, SHORT + 1);
    repeat (CAL + 4) @(negedge clk);

    // R10: request during the long power-up wait
    longDelay = 1'b1; calReq = 1'b0;
    enterReset();
    leaveReset();
    repeat (LOW) @(negedge clk);
    hold(1'b1, LONG + 2 * CAL);
    check(riseCount == 1, "R10 single start", riseCount, 1);
    check(riseAt == rel + LOW + HIGH + 1, "R10 early start", riseAt - rel, LOW + HIGH + 1);

    summary();
  end

endmodule